// File: doc/BRIEF.md
# Programmable-Priority Interrupt Vector Generator

This block takes a word of pending interrupt sources and reports, for each of two interrupt paths, which pending source should be served next. One path is the fast path (FIQ) and the other is the normal path (IRQ). A steering bit per source sends that source to exactly one of the two paths. Each source also has its own 2-bit urgency level, and that level does not depend on the steering.

Each path picks its winner in two stages. The first stage keeps only the pending sources at the most urgent level present on that path. The second stage picks the highest-numbered source among those. The winner's number is registered into a per-path vector together with a valid flag. Both vectors are visible on dedicated output ports and through a small register bus. Software uses the same bus to program the levels, the steering and a global enable.

Register writes are synchronous. Register reads are combinational from the address. A parameter marks which sources exist. A source that does not exist holds no configuration and can never win.

Top module: `prio_vector_gen`

## Requirements
- R1: After reset, every level field is 00, every steering bit is 0 and the enable is 0. Both valid flags are low, and reads of addresses 0 to 5 return zero.
- R2: Address 0 holds the levels of sources 0 to 15 and address 1 holds those of sources 16 to 31. Source k uses bits [2*(k mod 16)+1 : 2*(k mod 16)] of its word. A written field reads back unchanged.
- R3: A level value of 00 is the most urgent. The values 01, 10 and 11 are successively less urgent.
- R4: Address 2 is the steering word. Bit k set to 1 routes source k to the fast path, and 0 routes it to the normal path. A source is never considered on the path it is not routed to.
- R5: On each path, a pending source at a more urgent level beats every pending source at a less urgent level, whatever their indices.
- R6: When several pending sources on a path share the winning level, the one with the highest index wins.
- R7: Bit 0 of address 3 enables vector generation. While it is 0, both valid flags are low even if sources are pending.
- R8: Address 4 (fast path) and address 5 (normal path) are read-only vector words. Each has the valid flag in bit 31 and the source number in bits 4:0, and all other bits are zero. The source number is 0 whenever the flag is low. Writes to these addresses have no effect.
- R9: The vector outputs are registered. They reflect the pending word and the configuration present at the previous rising clock edge, and they do not change between edges.
- R10: Source 29 is unimplemented in the default build. Its level field and steering bit read 0 and ignore writes, and asserting its pending input never produces a vector.
- R11: Addresses 6 and 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| src_pend | input | 32 | Pending flag per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from address) |
| fiq_valid | output | 1 | Fast-path vector valid |
| fiq_vec | output | 5 | Fast-path winning source number |
| irq_valid | output | 1 | Normal-path vector valid |
| irq_vec | output | 5 | Normal-path winning source number |

## Verification
The bench places pending sources at different levels so that a low-index urgent source must beat a high-index lax source. A design that arbitrated by index alone would return the wrong number there. It also builds ties at one level to catch a lowest-bit-first encoder, and moves a single source between paths to catch steering that leaks into the other path. The reserved source is pended on its own, which exposes a design that lets it raise a vector or keeps its written field. Finally, the bench samples the outputs just before and just after the edge that takes in a pending change, so a design with combinational outputs or an extra register stage would miss by one cycle.

// File: rtl/ivg_pkg.sv
// Package: shared sizing constants for the interrupt vector generator.
// Assumes at most 32 sources so that the steering word fits one data word.
package ivg_pkg;
    localparam int unsigned IVG_SRC    = 32;
    localparam int unsigned IVG_LVL_W  = 2;
    localparam int unsigned IVG_DATA_W = 32;
    localparam int unsigned IVG_ADDR_W = 3;

    // Path selector used when the resolver pair is generated.
    typedef enum logic {
        PATH_NORMAL = 1'b0,
        PATH_FAST   = 1'b1
    } path_e;
endpackage

// File: rtl/ivg_regs.sv
// Module: ivg_regs
// Holds the level fields, the steering word and the enable bit, and muxes
// register reads. Fields of sources whose IMPL_MASK bit is 0 are held at zero.
// Assumes N_SRC * LVL_W is a multiple of DATA_W and that N_SRC <= DATA_W.
module ivg_regs #(
    parameter int unsigned N_SRC     = 32,
    parameter int unsigned LVL_W     = 2,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 3,
    parameter logic [N_SRC-1:0] IMPL_MASK = '1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [DATA_W-1:0]       fast_word,
    input  logic [DATA_W-1:0]       norm_word,
    output logic [DATA_W-1:0]       rdata,
    output logic [N_SRC*LVL_W-1:0]  prio_flat,
    output logic [N_SRC-1:0]        steer,
    output logic                    enable
);
    localparam int unsigned PRIO_REGS = (N_SRC * LVL_W) / DATA_W;
    localparam int unsigned A_STEER   = PRIO_REGS;
    localparam int unsigned A_EN      = PRIO_REGS + 1;
    localparam int unsigned A_FAST    = PRIO_REGS + 2;
    localparam int unsigned A_NORM    = PRIO_REGS + 3;

    logic [N_SRC*LVL_W-1:0] field_mask;
    logic [N_SRC*LVL_W-1:0] prio_q;
    logic [N_SRC-1:0]       steer_q;
    logic                   en_q;

    // Expand the implemented-source mask to one bit per level-field bit.
    for (genvar k = 0; k < N_SRC; k++) begin : g_fmask
        assign field_mask[k*LVL_W +: LVL_W] = {LVL_W{IMPL_MASK[k]}};
    end

    // Store level words; reserved fields are forced to zero on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
        end else if (we) begin
            for (int r = 0; r < int'(PRIO_REGS); r++) begin
                if (addr == ADDR_W'(r)) begin
                    prio_q[r*DATA_W +: DATA_W] <= wdata & field_mask[r*DATA_W +: DATA_W];
                end
            end
        end
    end

    // Store the steering word, keeping reserved sources at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            steer_q <= '0;
        end else if (we && addr == ADDR_W'(A_STEER)) begin
            steer_q <= wdata[N_SRC-1:0] & IMPL_MASK;
        end
    end

    // Store the vector-generation enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (we && addr == ADDR_W'(A_EN)) begin
            en_q <= wdata[0];
        end
    end

    // Select read data by address; unmapped addresses read zero.
    always_comb begin
        rdata = '0;
        for (int r = 0; r < int'(PRIO_REGS); r++) begin
            if (addr == ADDR_W'(r)) rdata = prio_q[r*DATA_W +: DATA_W];
        end
        if (addr == ADDR_W'(A_STEER)) rdata = DATA_W'(steer_q);
        if (addr == ADDR_W'(A_EN))    rdata = DATA_W'(en_q);
        if (addr == ADDR_W'(A_FAST))  rdata = fast_word;
        if (addr == ADDR_W'(A_NORM))  rdata = norm_word;
    end

    assign prio_flat = prio_q;
    assign steer     = steer_q;
    assign enable    = en_q;

    // R10: a reserved field or steering bit never holds a one.
    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((prio_q & ~field_mask) == '0) && ((steer_q & ~IMPL_MASK) == '0));

    // R11: a write to an unmapped address leaves every stored register unchanged.
    assert_unmapped_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr > ADDR_W'(A_NORM)) |=> ($stable(prio_q) && $stable(steer_q) && $stable(en_q)));
endmodule

// File: rtl/ivg_hibit.sv
// Module: ivg_hibit
// Finds the highest set bit of a candidate word and reports whether any bit
// was set. Purely combinational.
module ivg_hibit #(
    parameter int unsigned N_SRC = 32,
    localparam int unsigned IW   = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] cand,
    output logic             found,
    output logic [IW-1:0]    idx
);
    // Scan upward so that the last set bit seen, the highest, is kept.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < int'(N_SRC); k++) begin
            if (cand[k]) begin
                found = 1'b1;
                idx   = IW'(k);
            end
        end
    end
endmodule

// File: rtl/ivg_resolve.sv
// Module: ivg_resolve
// Two-stage winner selection for one path: first the most urgent level that
// has a request, then the highest-numbered request at that level.
// Assumes level 0 is the most urgent. clk and rst_n only clock the assertions.
module ivg_resolve #(
    parameter int unsigned N_SRC = 32,
    parameter int unsigned LVL_W = 2,
    localparam int unsigned IW   = $clog2(N_SRC),
    localparam int unsigned NLVL = 1 << LVL_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        req,
    input  logic [N_SRC*LVL_W-1:0]  lvl_flat,
    output logic                    any,
    output logic [IW-1:0]           idx
);
    logic [N_SRC-1:0] at_lvl [NLVL];
    logic [NLVL-1:0]  lvl_hit;
    logic [LVL_W-1:0] win_lvl;
    logic [N_SRC-1:0] cand;

    // Stage 1 decode: which sources sit at each level, and which levels have requests.
    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
        for (genvar k = 0; k < N_SRC; k++) begin : g_src
            assign at_lvl[l][k] = (lvl_flat[k*LVL_W +: LVL_W] == LVL_W'(l));
        end
        assign lvl_hit[l] = |(req & at_lvl[l]);
    end

    // Stage 1 pick: the lowest-numbered (most urgent) level with a request.
    always_comb begin
        win_lvl = '0;
        for (int l = int'(NLVL) - 1; l >= 0; l--) begin
            if (lvl_hit[l]) win_lvl = LVL_W'(l);
        end
    end

    // Stage 2 candidates: requests at the winning level only.
    always_comb begin
        cand = req & at_lvl[win_lvl];
    end

    ivg_hibit #(.N_SRC(N_SRC)) u_hibit (
        .cand  (cand),
        .found (any),
        .idx   (idx)
    );

    // Cross-check terms computed directly from the requests, not from the stages.
    logic beaten;
    logic tie_above;
    always_comb begin
        beaten    = 1'b0;
        tie_above = 1'b0;
        for (int k = 0; k < int'(N_SRC); k++) begin
            if (req[k]) begin
                if (lvl_flat[k*LVL_W +: LVL_W] < lvl_flat[idx*LVL_W +: LVL_W]) beaten = 1'b1;
                if (k > int'(idx) && lvl_flat[k*LVL_W +: LVL_W] == lvl_flat[idx*LVL_W +: LVL_W])
                    tie_above = 1'b1;
            end
        end
    end

    // R6: the reported source is actually requesting.
    assert_win_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> req[idx]);
    // R5: no request sits at a more urgent level than the winner.
    assert_level_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> !beaten);
    // R6: no higher-numbered request shares the winner's level.
    assert_tie_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> !tie_above);
    // R5: any request at all yields a winner.
    assert_found_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> any);
endmodule

// File: rtl/ivg_vec_reg.sv
// Module: ivg_vec_reg
// Registers one path's winner and valid flag. The number is forced to zero
// when there is no valid vector.
module ivg_vec_reg #(
    parameter int unsigned N_SRC = 32,
    localparam int unsigned IW   = $clog2(N_SRC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          any,
    input  logic [IW-1:0] idx,
    output logic          valid,
    output logic [IW-1:0] vec
);
    // Capture the gated winner once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            vec   <= '0;
        end else begin
            valid <= enable & any;
            vec   <= (enable & any) ? idx : '0;
        end
    end

    // R7: with generation disabled, the next vector is not valid.
    assert_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !valid);
    // R8: an invalid vector always carries number zero.
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (vec == '0));
endmodule

// File: rtl/prio_vector_gen.sv
// Module: prio_vector_gen (top)
// Routes pending sources to the fast or normal path by steering bit, resolves
// each path by level and then by index, and registers the two vectors.
// Assumes pending inputs are already synchronous to clk and held as levels.
module prio_vector_gen
    import ivg_pkg::*;
#(
    parameter int unsigned N_SRC  = IVG_SRC,
    parameter int unsigned LVL_W  = IVG_LVL_W,
    parameter int unsigned DATA_W = IVG_DATA_W,
    parameter int unsigned ADDR_W = IVG_ADDR_W,
    parameter logic [N_SRC-1:0] IMPL_MASK = 32'hDFFF_FFFF,
    localparam int unsigned IW    = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_pend,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              fiq_valid,
    output logic [IW-1:0]     fiq_vec,
    output logic              irq_valid,
    output logic [IW-1:0]     irq_vec
);
    logic [N_SRC*LVL_W-1:0] prio_flat;
    logic [N_SRC-1:0]       steer;
    logic                   enable;
    logic [DATA_W-1:0]      fast_word;
    logic [DATA_W-1:0]      norm_word;

    logic [N_SRC-1:0] path_req [2];
    logic             path_any [2];
    logic [IW-1:0]    path_idx [2];
    logic             path_vld [2];
    logic [IW-1:0]    path_vec [2];

    ivg_regs #(
        .N_SRC(N_SRC), .LVL_W(LVL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IMPL_MASK(IMPL_MASK)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .fast_word (fast_word),
        .norm_word (norm_word),
        .rdata     (reg_rdata),
        .prio_flat (prio_flat),
        .steer     (steer),
        .enable    (enable)
    );

    // One resolver and one vector register per path; p selects the steering sense.
    for (genvar p = 0; p < 2; p++) begin : g_path
        localparam path_e PATH = path_e'(p);
        if (PATH == PATH_FAST) begin : g_fast
            assign path_req[p] = src_pend & IMPL_MASK & steer;
        end else begin : g_norm
            assign path_req[p] = src_pend & IMPL_MASK & ~steer;
        end

        ivg_resolve #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_resolve (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (path_req[p]),
            .lvl_flat (prio_flat),
            .any      (path_any[p]),
            .idx      (path_idx[p])
        );

        ivg_vec_reg #(.N_SRC(N_SRC)) u_vec (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (enable),
            .any    (path_any[p]),
            .idx    (path_idx[p]),
            .valid  (path_vld[p]),
            .vec    (path_vec[p])
        );
    end

    assign fiq_valid = path_vld[PATH_FAST];
    assign fiq_vec   = path_vec[PATH_FAST];
    assign irq_valid = path_vld[PATH_NORMAL];
    assign irq_vec   = path_vec[PATH_NORMAL];

    // Read-only vector words: flag in the top bit, number in the low bits.
    assign fast_word = {fiq_valid, {(DATA_W-1-IW){1'b0}}, fiq_vec};
    assign norm_word = {irq_valid, {(DATA_W-1-IW){1'b0}}, irq_vec};

    // R4: a fast-path winner is steered fast; a normal-path winner is steered normal.
    assert_steer_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
        path_any[PATH_FAST] |-> steer[path_idx[PATH_FAST]]);
    assert_steer_norm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        path_any[PATH_NORMAL] |-> !steer[path_idx[PATH_NORMAL]]);
    // R10: a reserved source never wins on either path.
    assert_reserved_never_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!path_any[0] || IMPL_MASK[path_idx[0]]) && (!path_any[1] || IMPL_MASK[path_idx[1]]));
    // R9: an enabled request shows up as a valid vector one edge later.
    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && path_any[PATH_FAST]) |=> fiq_valid);
endmodule

// File: tb/prio_vector_gen_test.sv
`timescale 1ns/1ps
module prio_vector_gen_test;
    localparam logic [31:0] IMPL = 32'hDFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_pend = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fiq_valid, irq_valid;
    logic [4:0]  fiq_vec, irq_vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int          m_lvl [32];
    logic [31:0] m_steer;
    logic        m_en;

    always #2.5 clk = ~clk;

    prio_vector_gen uut (
        .clk(clk), .rst_n(rst_n), .src_pend(src_pend),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fiq_valid(fiq_valid), .fiq_vec(fiq_vec), .irq_valid(irq_valid), .irq_vec(irq_vec)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected vector word for one path from the bench model: {valid, 26'b0, number}.
    function automatic logic [31:0] exp_word(input logic [31:0] pend, input bit fast);
        int best = -1;
        int bl = 4;
        for (int k = 0; k < 32; k++) begin
            if (m_en && IMPL[k] && pend[k] && (m_steer[k] == fast) && m_lvl[k] <= bl) begin
                bl = m_lvl[k];
                best = k;
            end
        end
        if (best < 0) return 32'h0;
        return {1'b1, 26'b0, 5'(best)};
    endfunction

    function automatic logic [31:0] model_prio_word(input int r);
        logic [31:0] w = '0;
        for (int j = 0; j < 16; j++) w[2*j +: 2] = 2'(m_lvl[r*16 + j]);
        return w;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
        if (a <= 3'd1) begin
            for (int j = 0; j < 16; j++)
                m_lvl[a*16 + j] = IMPL[a*16 + j] ? int'(d[2*j +: 2]) : 0;
        end else if (a == 3'd2) begin
            m_steer = d & IMPL;
        end else if (a == 3'd3) begin
            m_en = d[0];
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_lvl(input int src, input int lvl);
        logic [31:0] w;
        m_lvl[src] = IMPL[src] ? lvl : 0;
        w = model_prio_word(src / 16);
        wr(3'(src / 16), w);
    endtask

    // Apply a pending word and let one edge register it, then compare both paths.
    task automatic pend_check(input logic [31:0] p, input string req);
        @(negedge clk);
        src_pend = p;
        @(posedge clk); #1;
        chk(req, {fiq_valid, 26'b0, fiq_vec}, exp_word(p, 1'b1));
        chk(req, {irq_valid, 26'b0, irq_vec}, exp_word(p, 1'b0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1357));
        for (int k = 0; k < 32; k++) m_lvl[k] = 0;
        m_steer = '0;
        m_en = 1'b0;

        // R1: reset state.
        src_pend = 32'hFFFF_FFFF;
        repeat (4) @(posedge clk);
        #1;
        chk("R1 valid in reset", {30'b0, fiq_valid, irq_valid}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 valid after reset (enable 0)", {30'b0, fiq_valid, irq_valid}, 32'h0);
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            chk("R1 reset read", d, 32'h0);
        end
        src_pend = '0;

        // R2/R10: level readback, reserved source 29 field stays zero.
        wr(3'd0, 32'hA5C3_1E96);
        rd(3'd0, d); chk("R2 level word 0 readback", d, 32'hA5C3_1E96);
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, d); chk("R10 level word 1 with reserved field", d, 32'hF3FF_FFFF);
        // R10: steering bit of source 29 ignores writes.
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, d); chk("R10 steering readback", d, IMPL);
        // R11: unmapped addresses read zero and change nothing.
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'h1234_5678);
        rd(3'd6, d); chk("R11 addr 6 reads zero", d, 32'h0);
        rd(3'd7, d); chk("R11 addr 7 reads zero", d, 32'h0);
        rd(3'd2, d); chk("R11 steering unchanged", d, IMPL);
        rd(3'd3, d); chk("R11 enable unchanged", d, 32'h0);
        // R8: writes to vector words have no effect.
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, d); chk("R8 fast vector word read-only", d, 32'h0);

        // R7: disabled generation gives no valid vector.
        wr(3'd0, 32'h0); wr(3'd1, 32'h0); wr(3'd2, 32'h0);
        pend_check(32'hFFFF_FFFF, "R7 disabled");

        wr(3'd3, 32'h1);
        // R3/R5: source 3 at 00 beats source 31 at 11 on the normal path.
        set_lvl(31, 3); set_lvl(3, 0);
        pend_check(32'h8000_0008, "R5 urgent low index wins");
        chk("R3/R5 normal vector 3", {irq_valid, 26'b0, irq_vec}, {1'b1, 26'b0, 5'd3});
        // R3: 10 beats 11.
        set_lvl(3, 2);
        pend_check(32'h8000_0008, "R3 level 10 over 11");
        // R6: tie at level 01 goes to the higher index.
        set_lvl(5, 1); set_lvl(9, 1);
        pend_check(32'h0000_0220, "R6 tie");
        chk("R6 normal vector 9", {irq_valid, 26'b0, irq_vec}, {1'b1, 26'b0, 5'd9});
        // R4: steer source 9 to the fast path.
        wr(3'd2, 32'h0000_0200);
        pend_check(32'h0000_0220, "R4 steering split");
        chk("R4 fast vector 9", {fiq_valid, 26'b0, fiq_vec}, {1'b1, 26'b0, 5'd9});
        chk("R4 normal vector 5", {irq_valid, 26'b0, irq_vec}, {1'b1, 26'b0, 5'd5});
        // R8: vector words through the bus.
        rd(3'd4, d); chk("R8 fast word", d, 32'h8000_0009);
        rd(3'd5, d); chk("R8 normal word", d, 32'h8000_0005);
        // R10: reserved source alone never produces a vector.
        wr(3'd2, 32'h2000_0000);
        pend_check(32'h2000_0000, "R10 reserved pending");
        wr(3'd2, 32'h0);
        pend_check(32'h2000_0000, "R10 reserved pending normal");

        // R9: output holds until the edge that takes in the new pending word.
        pend_check(32'h0000_0020, "R9 setup");
        @(negedge clk);
        src_pend = 32'h0000_0200;
        #1 chk("R9 before edge", {irq_valid, 26'b0, irq_vec}, {1'b1, 26'b0, 5'd5});
        @(posedge clk); #1;
        chk("R9 after edge", {irq_valid, 26'b0, irq_vec}, {1'b1, 26'b0, 5'd9});
        // R7: disabling clears valid one edge after the write.
        wr(3'd3, 32'h0);
        @(posedge clk); #1;
        chk("R7 disable clears", {30'b0, fiq_valid, irq_valid}, 32'h0);
        wr(3'd3, 32'h1);

        // Random mix of configuration changes and pending words.
        for (int i = 0; i < 400; i++) begin
            int sel = int'($urandom_range(0, 9));
            if (sel == 0) wr(3'd0, $urandom);
            else if (sel == 1) wr(3'd1, $urandom);
            else if (sel == 2) wr(3'd2, $urandom);
            else if (sel == 3 && ($urandom_range(0, 3) == 0)) wr(3'd3, 32'($urandom_range(0, 1)));
            if ($urandom_range(0, 1) == 0)
                pend_check($urandom & $urandom, "R5/R6 random");
            else
                pend_check(32'(1) << $urandom_range(0, 31), "R4 random single");
            if (i % 50 == 0) begin
                rd(3'd4, d); chk("R8 random fast word", d, exp_word(src_pend, 1'b1));
                rd(3'd5, d); chk("R8 random normal word", d, exp_word(src_pend, 1'b0));
                rd(3'd0, d); chk("R2 random word 0", d, model_prio_word(0));
                rd(3'd1, d); chk("R2 random word 1", d, model_prio_word(1));
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule